// File: doc/BRIEF.md
# Sampled Cache Fill Controller

This block decides when the small prefix caches that sit beside a set of parallel search engines are refilled. It does not write a cache after every miss. It takes one miss as a sample, waits a programmable interval of D clock cycles, and then issues a single cache write for that miss. Every other miss seen while that update is pending is dropped and counted. The expanded, disjoint prefix that belongs in the cache comes in with the miss. Because cache entries never overlap, a write is a single cycle into any free slot and needs no ordering.

Each engine's cache tracks least-recently-used order with one age counter per entry. Cache hits reported by the engines make an entry the most recent. A write puts the new prefix in the oldest entry and makes that entry the most recent. Before it writes, the block raises a busy request to the owning engine and waits for that engine's acknowledge, because the engine cannot search while its cache is written. Software can lower D during warm-up and raise it for steady state. A new value applies from the next sampling window.

Top module: `cache_fill_sampler`

## Requirements
- R1: After reset, `busy_req` is all zero, `wr_valid` is low and `miss_drops` is zero.
- R2: When the block is idle and `miss_valid` is high in cycle t, that miss is captured. If the owning engine acknowledges at once, `wr_valid` is high in cycle t+D and carries the miss's engine number and prefix.
- R3: A miss presented in any cycle from t+1 through t+D produces no write, and each one adds 1 to `miss_drops`. A miss in cycle t+D+1 is captured as a new sample.
- R4: `busy_req` is one-hot, with bit e set for captured engine e. It is high from cycle t+D-1 through the cycle in which `wr_valid` is high, and it is zero in the next cycle.
- R5: `wr_valid` rises in the cycle after the first cycle in which `busy_req[e]` and `busy_ack[e]` are both high. Until then `busy_req` holds, misses are dropped, and no new window opens.
- R6: `wr_valid` is high for exactly one cycle per captured miss.
- R7: `wr_index` is the least-recently-used entry of the target engine's cache. After reset, higher entry numbers count as older, so entry ENTRIES-1 is replaced first. A written entry becomes the most recent.
- R8: A pulse on `hit_valid` makes entry `hit_index` of engine `hit_engine` the most recent. This changes later victim choices.
- R9: `cfg_interval` is sampled when a miss is captured. A change while a window is open affects only later windows.
- R10: A `cfg_interval` value below 3 acts as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | DW | Sampling interval D in cycles |
| miss_valid | input | 1 | A cache miss is reported this cycle |
| miss_engine | input | EW | Engine that saw the miss |
| miss_prefix | input | PW | Expanded prefix to install for that miss |
| hit_valid | input | 1 | A cache hit is reported this cycle |
| hit_engine | input | EW | Engine that hit |
| hit_index | input | IW | Cache entry that hit |
| busy_ack | input | N_ENG | Engine has stopped lookups for a write |
| busy_req | output | N_ENG | One-hot request that the engine stop lookups |
| wr_valid | output | 1 | Cache write strobe |
| wr_engine | output | EW | Engine whose cache is written |
| wr_index | output | IW | Entry being replaced |
| wr_prefix | output | PW | Prefix written |
| miss_drops | output | CW | Count of ignored misses |

## Verification
The bench uses three miss patterns. A single isolated miss pins the write cycle to t+D. A burst of misses placed at t+1 and t+D, followed by one at t+D+1, shows where the ignore window starts and ends. A miss whose acknowledge is held back separates the timer from the handshake. A change to D in the middle of a window, and values of D below 3, show when the interval is latched and how it is clamped. Hits aimed at the current victim of an engine show that recency is refreshed and not only advanced by writes.

// File: rtl/fill_sampler_pkg.sv
package fill_sampler_pkg;
  typedef enum logic [1:0] {
    UPD_IDLE  = 2'd0,
    UPD_WAIT  = 2'd1,
    UPD_REQ   = 2'd2,
    UPD_WRITE = 2'd3
  } upd_state_e;

  localparam int MIN_INTERVAL = 3;
endpackage

// File: rtl/lru_age_bank.sv
module lru_age_bank #(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // age 0 = most recent, ENTRIES-1 = least recent; ages stay a permutation
  logic [IW-1:0] age_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IW'(j);
    end else if (touch) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IW'(j) == touch_idx)
          age_q[j] <= '0;
        else if (age_q[j] < age_q[touch_idx])
          age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (age_q[j] == IW'(ENTRIES - 1)) victim_idx = IW'(j);
  end
endmodule

// File: rtl/update_sequencer.sv
module update_sequencer
  import fill_sampler_pkg::*;
#(
  parameter int N_ENG = 4,
  parameter int ENTRIES = 8,
  parameter int PW = 32,
  parameter int DW = 16,
  localparam int EW = $clog2(N_ENG),
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    cfg_interval,
  input  logic             miss_valid,
  input  logic [EW-1:0]    miss_engine,
  input  logic [PW-1:0]    miss_prefix,
  input  logic [N_ENG-1:0] busy_ack,
  input  logic [IW-1:0]    victim_sel,
  output logic [EW-1:0]    cap_engine,
  output logic             commit,
  output logic             drop,
  output logic [N_ENG-1:0] busy_req,
  output logic             wr_valid,
  output logic [EW-1:0]    wr_engine,
  output logic [IW-1:0]    wr_index,
  output logic [PW-1:0]    wr_prefix
);
  upd_state_e    state_q;
  logic [DW-1:0] cnt_q;
  logic [PW-1:0] pfx_q;
  logic [DW-1:0] d_eff;

  assign d_eff  = (cfg_interval < DW'(MIN_INTERVAL)) ? DW'(MIN_INTERVAL) : cfg_interval;
  assign commit = (state_q == UPD_REQ) && busy_ack[cap_engine];
  assign drop   = miss_valid && (state_q != UPD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= UPD_IDLE;
      cnt_q      <= '0;
      cap_engine <= '0;
      pfx_q      <= '0;
      busy_req   <= '0;
      wr_valid   <= 1'b0;
      wr_engine  <= '0;
      wr_index   <= '0;
      wr_prefix  <= '0;
    end else begin
      wr_valid <= 1'b0;
      case (state_q)
        UPD_IDLE: if (miss_valid) begin
          state_q    <= UPD_WAIT;
          cnt_q      <= d_eff - DW'(MIN_INTERVAL);
          cap_engine <= miss_engine;
          pfx_q      <= miss_prefix;
        end
        UPD_WAIT: begin
          if (cnt_q == '0) begin
            state_q  <= UPD_REQ;
            busy_req <= N_ENG'(1) << cap_engine;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        UPD_REQ: if (commit) begin
          state_q   <= UPD_WRITE;
          wr_valid  <= 1'b1;
          wr_engine <= cap_engine;
          wr_index  <= victim_sel;
          wr_prefix <= pfx_q;
        end
        default: begin
          state_q  <= UPD_IDLE;
          busy_req <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && (count != {CW{1'b1}}))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/cache_fill_sampler.sv
module cache_fill_sampler #(
  parameter int N_ENG = 4,
  parameter int ENTRIES = 8,
  parameter int PW = 32,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int EW = $clog2(N_ENG),
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    cfg_interval,
  input  logic             miss_valid,
  input  logic [EW-1:0]    miss_engine,
  input  logic [PW-1:0]    miss_prefix,
  input  logic             hit_valid,
  input  logic [EW-1:0]    hit_engine,
  input  logic [IW-1:0]    hit_index,
  input  logic [N_ENG-1:0] busy_ack,
  output logic [N_ENG-1:0] busy_req,
  output logic             wr_valid,
  output logic [EW-1:0]    wr_engine,
  output logic [IW-1:0]    wr_index,
  output logic [PW-1:0]    wr_prefix,
  output logic [CW-1:0]    miss_drops
);
  logic [EW-1:0] cap_engine;
  logic          commit;
  logic          drop;
  logic [IW-1:0] victim [N_ENG];
  logic [IW-1:0] victim_sel;

  assign victim_sel = victim[cap_engine];

  update_sequencer #(
    .N_ENG(N_ENG), .ENTRIES(ENTRIES), .PW(PW), .DW(DW)
  ) u_seq (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval),
    .miss_valid(miss_valid), .miss_engine(miss_engine), .miss_prefix(miss_prefix),
    .busy_ack(busy_ack), .victim_sel(victim_sel),
    .cap_engine(cap_engine), .commit(commit), .drop(drop),
    .busy_req(busy_req), .wr_valid(wr_valid), .wr_engine(wr_engine),
    .wr_index(wr_index), .wr_prefix(wr_prefix)
  );

  drop_counter #(.CW(CW)) u_drops (
    .clk(clk), .rst(rst), .inc(drop), .count(miss_drops)
  );

  for (genvar g = 0; g < N_ENG; g++) begin : g_bank
    logic          own_write;
    logic          own_hit;
    logic          touch;
    logic [IW-1:0] touch_idx;

    // a write to this cache wins over a hit reported in the same cycle
    assign own_write = commit && (cap_engine == EW'(g));
    assign own_hit   = hit_valid && (hit_engine == EW'(g));
    assign touch     = own_write || own_hit;
    assign touch_idx = own_write ? victim[g] : hit_index;

    lru_age_bank #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
      .victim_idx(victim[g])
    );
  end
endmodule

// File: rtl/fill_sampler_checks.sv
module fill_sampler_checks #(
  parameter int N_ENG = 4,
  parameter int ENTRIES = 8,
  parameter int CW = 16,
  localparam int EW = $clog2(N_ENG)
) (
  input logic             clk,
  input logic             rst,
  input logic             miss_valid,
  input logic [N_ENG-1:0] busy_req,
  input logic             wr_valid,
  input logic [EW-1:0]    wr_engine,
  input logic [CW-1:0]    miss_drops
);
  assert_req_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy_req));

  assert_write_under_req_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> busy_req[wr_engine]);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_req != '0 && !wr_valid) |=> busy_req == $past(busy_req));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  assert_req_drops_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> busy_req == '0);

  assert_drop_counted_R3: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && busy_req != '0 && miss_drops != {CW{1'b1}})
      |=> miss_drops == $past(miss_drops) + 1'b1);
endmodule

bind cache_fill_sampler fill_sampler_checks #(
  .N_ENG(N_ENG), .ENTRIES(ENTRIES), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .busy_req(busy_req),
  .wr_valid(wr_valid), .wr_engine(wr_engine), .miss_drops(miss_drops)
);

// File: tb/sim_cache_fill_sampler.sv
module sim_cache_fill_sampler;
  localparam int PERIOD = 10;
  localparam int N_ENG = 4;
  localparam int ENTRIES = 8;
  localparam int PW = 32;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int EW = $clog2(N_ENG);
  localparam int IW = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DW-1:0]    cfg_interval = 16'd10;
  logic             miss_valid = 1'b0;
  logic [EW-1:0]    miss_engine = '0;
  logic [PW-1:0]    miss_prefix = '0;
  logic             hit_valid = 1'b0;
  logic [EW-1:0]    hit_engine = '0;
  logic [IW-1:0]    hit_index = '0;
  logic [N_ENG-1:0] ack_en = '1;
  logic [N_ENG-1:0] busy_ack;
  logic [N_ENG-1:0] busy_req;
  logic             wr_valid;
  logic [EW-1:0]    wr_engine;
  logic [IW-1:0]    wr_index;
  logic [PW-1:0]    wr_prefix;
  logic [CW-1:0]    miss_drops;

  int checks = 0;
  int errors = 0;
  int lru_ord [N_ENG][ENTRIES];  // position 0 = most recent

  assign busy_ack = busy_req & ack_en;
  always #(PERIOD/2) clk = ~clk;

  cache_fill_sampler #(
    .N_ENG(N_ENG), .ENTRIES(ENTRIES), .PW(PW), .DW(DW), .CW(CW)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval),
    .miss_valid(miss_valid), .miss_engine(miss_engine), .miss_prefix(miss_prefix),
    .hit_valid(hit_valid), .hit_engine(hit_engine), .hit_index(hit_index),
    .busy_ack(busy_ack), .busy_req(busy_req), .wr_valid(wr_valid),
    .wr_engine(wr_engine), .wr_index(wr_index), .wr_prefix(wr_prefix),
    .miss_drops(miss_drops)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int lru_victim(input int e);
    return lru_ord[e][ENTRIES-1];
  endfunction

  task automatic lru_touch(input int e, input int idx);
    int pos = 0;
    for (int k = 0; k < ENTRIES; k++) if (lru_ord[e][k] == idx) pos = k;
    for (int k = pos; k > 0; k--) lru_ord[e][k] = lru_ord[e][k-1];
    lru_ord[e][0] = idx;
  endtask

  // present a miss in the current cycle t and follow it to the write at t+d
  task automatic run_update(input int eng, input logic [PW-1:0] pfx, input int d, input string req);
    int exp_idx = lru_victim(eng);
    miss_valid = 1'b1; miss_engine = EW'(eng); miss_prefix = pfx;
    tick(); miss_valid = 1'b0;
    for (int k = 1; k < d - 1; k++) begin
      chk(busy_req == '0 && !wr_valid, {req, " quiet window"}, {busy_req, wr_valid}, 0);
      tick();
    end
    chk(busy_req == N_ENG'(1 << eng) && !wr_valid, "R4 busy at t+D-1", busy_req, 1 << eng);
    tick();
    chk(wr_valid, {req, " write at t+D"}, wr_valid, 1);
    chk(wr_engine == EW'(eng) && wr_prefix == pfx, "R2 write fields", {wr_engine, wr_prefix}, {EW'(eng), pfx});
    chk(wr_index == IW'(exp_idx), "R7 LRU victim", wr_index, exp_idx);
    chk(busy_req == N_ENG'(1 << eng), "R4 busy during write", busy_req, 1 << eng);
    lru_touch(eng, exp_idx);
    tick();
    chk(!wr_valid, "R6 single pulse", wr_valid, 0);
    chk(busy_req == '0, "R4 busy released", busy_req, 0);
  endtask

  task automatic test_reset();
    chk(busy_req == '0 && !wr_valid, "R1 reset outputs", {busy_req, wr_valid}, 0);
    chk(miss_drops == '0, "R1 reset drops", miss_drops, 0);
  endtask

  task automatic test_basic();
    cfg_interval = 16'd10;
    run_update(1, 32'hA0B0_0001, 10, "R2");
    cfg_interval = 16'd4;
    run_update(1, 32'hA0B0_0002, 4, "R2");
  endtask

  task automatic test_ignore();
    int d0 = miss_drops;
    cfg_interval = 16'd8;
    miss_valid = 1'b1; miss_engine = 0; miss_prefix = 32'h1111_0000;
    tick();
    miss_engine = 2; miss_prefix = 32'hDEAD_0001;   // t+1: ignored
    tick(); miss_valid = 1'b0;
    for (int k = 2; k < 8; k++) tick();
    miss_valid = 1'b1; miss_engine = 2; miss_prefix = 32'hDEAD_0002; // t+D: ignored
    chk(wr_valid && wr_engine == 0 && wr_prefix == 32'h1111_0000, "R3 sampled miss written",
        wr_prefix, 32'h1111_0000);
    chk(wr_index == IW'(lru_victim(0)), "R7 victim engine 0", wr_index, lru_victim(0));
    lru_touch(0, lru_victim(0));
    tick(); miss_valid = 1'b0;
    chk(miss_drops == CW'(d0 + 2), "R3 drops counted", miss_drops, d0 + 2);
    chk(!wr_valid, "R3 ignored miss not written", wr_valid, 0);
    run_update(3, 32'h3333_0003, 8, "R3");  // t+D+1 is a fresh sample
  endtask

  task automatic test_interval_change();
    cfg_interval = 16'd12;
    miss_valid = 1'b1; miss_engine = 2; miss_prefix = 32'h2222_0001;
    tick(); miss_valid = 1'b0;
    tick(); cfg_interval = 16'd5;
    for (int k = 2; k < 12; k++) begin
      chk(!wr_valid, "R9 no early write", wr_valid, 0);
      tick();
    end
    chk(wr_valid && wr_prefix == 32'h2222_0001, "R9 old interval used", wr_valid, 1);
    lru_touch(2, lru_victim(2));
    tick();
    run_update(2, 32'h2222_0002, 5, "R9");
  endtask

  task automatic test_clamp();
    cfg_interval = 16'd1;
    run_update(0, 32'hC1A0_0001, 3, "R10");
    cfg_interval = 16'd0;
    run_update(3, 32'hC1A0_0002, 3, "R10");
  endtask

  task automatic test_late_ack();
    int d0;
    int exp_idx = lru_victim(2);
    cfg_interval = 16'd6;
    ack_en = '0;
    miss_valid = 1'b1; miss_engine = 2; miss_prefix = 32'h5A5A_0001;
    tick(); miss_valid = 1'b0;
    for (int k = 1; k < 5; k++) tick();
    chk(busy_req == 4'b0100, "R5 request raised", busy_req, 4'b0100);
    d0 = miss_drops;
    for (int k = 0; k < 4; k++) begin
      miss_valid = 1'b1; miss_engine = 1; miss_prefix = 32'hBAD0_0000;
      tick();
      chk(!wr_valid && busy_req == 4'b0100, "R5 wait for ack", {busy_req, wr_valid}, 4'b1000);
    end
    miss_valid = 1'b0;
    chk(miss_drops == CW'(d0 + 4), "R5 misses dropped while waiting", miss_drops, d0 + 4);
    ack_en = '1;
    tick();
    ack_en = '0;
    chk(wr_valid && wr_prefix == 32'h5A5A_0001, "R5 write after ack", wr_valid, 1);
    chk(wr_index == IW'(exp_idx), "R7 victim after wait", wr_index, exp_idx);
    lru_touch(2, exp_idx);
    tick();
    ack_en = '1;
    chk(!wr_valid && busy_req == '0, "R5 released", {busy_req, wr_valid}, 0);
  endtask

  task automatic test_hits();
    int v;
    cfg_interval = 16'd4;
    // touch the current victim, then two more entries
    for (int k = 0; k < 3; k++) begin
      v = (k == 0) ? lru_victim(1) : lru_ord[1][ENTRIES-1-k];
      hit_valid = 1'b1; hit_engine = 1; hit_index = IW'(v);
      lru_touch(1, v);
      tick();
    end
    hit_valid = 1'b0;
    chk(1'b1, "R8 hit stimulus applied", 0, 0);
    run_update(1, 32'h8888_0001, 4, "R8");
    // hit on another engine must not disturb engine 1 order
    hit_valid = 1'b1; hit_engine = 3; hit_index = IW'(lru_victim(3)); lru_touch(3, lru_victim(3));
    tick(); hit_valid = 1'b0;
    run_update(1, 32'h8888_0002, 4, "R8");
    run_update(3, 32'h8888_0003, 4, "R8");
  endtask

  initial begin
    for (int e = 0; e < N_ENG; e++)
      for (int k = 0; k < ENTRIES; k++) lru_ord[e][k] = k;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    test_reset();
    test_basic();
    test_ignore();
    test_interval_change();
    test_clamp();
    test_late_ack();
    test_hits();
    repeat (2) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule